// File: doc/BRIEF.md
# Window Alarm Monitor with Fault Capture

The block watches a stream of conversion results. Each result carries the index of the channel it belongs to, and the block supports one to four channels. Every result is compared with that channel's low and high 12-bit limits. A result outside the window raises a sticky alarm bit in an 8-bit status byte. When a channel's first alarm appears, the result that caused it is stored in a per-channel fault word.

The block's owner drives the limits as plain inputs. An alarm-reset strobe with a bit mask clears chosen status bits. The stored fault words are deliberately left untouched by that clear. A fault word is therefore meaningful only while one of its channel's status bits is set. An interrupt line reports that any alarm is pending, gated by an enable input.

Top module: `win_alarm_mon`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `alarm_status` is 0x00, every fault word is zero, and `irq` is 0.
- R2: A valid result on channel c that is strictly greater than that channel's high limit sets the channel's upper bit. A result equal to the high limit does not set it.
- R3: A valid result on channel c that is strictly less than that channel's low limit sets the channel's lower bit. A result equal to the low limit does not set it.
- R4: Status bit positions are fixed. Bit 7-2c is the upper alarm of channel c and bit 6-2c is its lower alarm (bit 7 = ch0 upper, bit 6 = ch0 lower, bit 0 = ch3 lower). A 1 means an alarm is pending. Bits of channels at or above NCH read 0.
- R5: A status bit that is set stays set, even when later results fall back inside the window, until a clear that selects it.
- R6: The fault word of channel c (bits c*12 and up of `fault_val`) takes the result's value only when that result turns one of the channel's status bits from 0 to 1. A later out-of-window result that finds the bit already set leaves the word unchanged.
- R7: A cycle with `alm_clr` high clears exactly the status bits whose `alm_clr_mask` bit (same positions as R4) is 1. If a result in that same cycle detects an alarm, the detection wins: the bit ends up set and counts as a new 0-to-1 change for R6.
- R8: Clearing status bits never changes any fault word.
- R9: With a low limit of 0x000 and a high limit of 0xFFF, no 12-bit result raises an alarm.
- R10: `irq` is 1 exactly when `irq_en` is 1 and at least one status bit is set. It follows `irq_en` with no added register.
- R11: Status and fault words change on the clock edge that samples the result. The new values are visible from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | A conversion result is present this cycle |
| res_chan | input | 2 | Channel index of the result |
| res_data | input | RW (12) | Conversion result |
| thr_lo | input | NCH*RW | Low limits, channel c at bits c*RW and up |
| thr_hi | input | NCH*RW | High limits, channel c at bits c*RW and up |
| alm_clr | input | 1 | Alarm-reset strobe |
| alm_clr_mask | input | 8 | Status bits to clear, same layout as alarm_status |
| irq_en | input | 1 | Interrupt enable |
| alarm_status | output | 8 | Sticky alarm bits, layout per R4 |
| fault_val | output | NCH*RW | Captured fault results, channel c at bits c*RW and up |
| irq | output | 1 | Interrupt request |

## Verification
Every state bit in this block is visible directly at a port, so a wrong status or fault register shows up in the cycle after the result that disturbed it. The subtle failures only appear across sequences. Examples are a fault word that is overwritten by a second excursion, one that is wiped by a clear, or a clear that loses to a simultaneous detection in the wrong order. For that reason, sweeps run on channels whose alarms are already latched, and clears are mixed with live results. An off-by-one in a comparison shows up only when a result lands exactly on a limit, so the limits and their neighbours are always included in the sweeps.

// File: rtl/win_alarm_mon.sv
module win_alarm_mon #(
  parameter int NCH = 4,
  parameter int RW  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            res_valid,
  input  logic [1:0]      res_chan,
  input  logic [RW-1:0]   res_data,
  input  logic [NCH*RW-1:0] thr_lo,
  input  logic [NCH*RW-1:0] thr_hi,
  input  logic            alm_clr,
  input  logic [7:0]      alm_clr_mask,
  input  logic            irq_en,
  output logic [7:0]      alarm_status,
  output logic [NCH*RW-1:0] fault_val,
  output logic            irq
);

  logic [NCH-1:0] st_up, st_dn;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit, over, under, keep_up, keep_dn, rise;

    assign hit     = res_valid && (res_chan == 2'(c));
    assign over    = hit && (res_data > thr_hi[c*RW +: RW]);
    assign under   = hit && (res_data < thr_lo[c*RW +: RW]);
    assign keep_up = st_up[c] && !(alm_clr && alm_clr_mask[7-2*c]);
    assign keep_dn = st_dn[c] && !(alm_clr && alm_clr_mask[6-2*c]);
    assign rise    = (over && !keep_up) || (under && !keep_dn);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_up[c] <= 1'b0;
        st_dn[c] <= 1'b0;
        fault_val[c*RW +: RW] <= '0;
      end else begin
        st_up[c] <= keep_up || over;
        st_dn[c] <= keep_dn || under;
        if (rise) fault_val[c*RW +: RW] <= res_data;
      end
    end

    AST_UP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_up[c] && !(alm_clr && alm_clr_mask[7-2*c])) |=> st_up[c]); // R5
    AST_DN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_dn[c] && !(alm_clr && alm_clr_mask[6-2*c])) |=> st_dn[c]); // R5
    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_valid && res_chan == 2'(c)) |=> $stable(fault_val[c*RW +: RW])); // R8
    AST_NO_SPONT: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_valid && res_chan == 2'(c)) |=> !$rose(st_up[c]) && !$rose(st_dn[c])); // R11
  end

  for (genvar c = 0; c < 4; c++) begin : g_map
    if (c < NCH) begin : g_used
      assign alarm_status[7-2*c] = st_up[c];
      assign alarm_status[6-2*c] = st_dn[c];
    end else begin : g_unused
      assign alarm_status[7-2*c] = 1'b0;
      assign alarm_status[6-2*c] = 1'b0;
    end
  end

  assign irq = irq_en && (alarm_status != 8'h00);

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq); // R10
  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rst_n |=> (alarm_status == 8'h00) && (fault_val == '0)); // R1

endmodule

// File: tb/win_alarm_mon_tb.sv
module win_alarm_mon_tb;
  localparam int NCH = 4;
  localparam int RW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 1'b0;
  logic [1:0] res_chan = '0;
  logic [RW-1:0] res_data = '0;
  logic [NCH*RW-1:0] thr_lo, thr_hi;
  logic alm_clr = 1'b0;
  logic [7:0] alm_clr_mask = '0;
  logic irq_en = 1'b0;
  logic [7:0] alarm_status;
  logic [NCH*RW-1:0] fault_val;
  logic irq;

  logic [RW-1:0] tlo [NCH];
  logic [RW-1:0] thi [NCH];
  logic [7:0]    exp_st;
  logic [RW-1:0] exp_f [NCH];
  int vectors = 0;
  int miscomp = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      thr_lo[c*RW +: RW] = tlo[c];
      thr_hi[c*RW +: RW] = thi[c];
    end
  end

  win_alarm_mon #(.NCH(NCH), .RW(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .thr_lo(thr_lo), .thr_hi(thr_hi), .alm_clr(alm_clr),
    .alm_clr_mask(alm_clr_mask), .irq_en(irq_en), .alarm_status(alarm_status),
    .fault_val(fault_val), .irq(irq));

  task automatic check(input string tag);
    logic [NCH*RW-1:0] ef;
    logic ei;
    for (int c = 0; c < NCH; c++) ef[c*RW +: RW] = exp_f[c];
    ei = irq_en && (exp_st != 8'h00);
    vectors++;
    if (alarm_status !== exp_st || fault_val !== ef || irq !== ei) begin
      miscomp++;
      $display("FAIL %s: status=%h fault=%h irq=%b expected status=%h fault=%h irq=%b",
               tag, alarm_status, fault_val, irq, exp_st, ef, ei);
    end
  endtask

  // called at a negedge: drives one cycle, updates model, checks at next negedge
  task automatic step(input bit v, input int ch, input int d, input bit clr,
                      input logic [7:0] mask, input string tag);
    res_valid = v; res_chan = 2'(ch); res_data = RW'(d);
    alm_clr = clr; alm_clr_mask = mask;
    if (clr) exp_st = exp_st & ~mask;
    if (v) begin
      bit u, l, cap;
      u = d > int'(thi[ch]);
      l = d < int'(tlo[ch]);
      cap = (u && !exp_st[7-2*ch]) || (l && !exp_st[6-2*ch]);
      if (u) exp_st[7-2*ch] = 1'b1;
      if (l) exp_st[6-2*ch] = 1'b1;
      if (cap) exp_f[ch] = RW'(d);
    end
    @(negedge clk);
    res_valid = 1'b0; alm_clr = 1'b0;
    check(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      miscomp++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      tlo[c] = 12'h000; thi[c] = 12'hFFF; exp_f[c] = '0;
    end
    exp_st = 8'h00;
    irq_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset");

    // R9: exhaustive on channel 0 with the disabling limits
    for (int d = 0; d < 4096; d++) step(1'b1, 0, d, 1'b0, 8'h00, "R9 open window");

    // R2 R3 R4 R5 R6 per-channel sweeps including limit neighbours
    for (int c = 0; c < NCH; c++) begin
      tlo[c] = 12'(12'h100 + c * 16);
      thi[c] = 12'(12'hE00 - c * 16);
      step(1'b1, c, int'(tlo[c]), 1'b0, 8'h00, "R3 equal low");
      step(1'b1, c, int'(thi[c]), 1'b0, 8'h00, "R2 equal high");
      step(1'b1, c, int'(thi[c]) + 1, 1'b0, 8'h00, "R2 R4 R6 just above");
      step(1'b1, c, int'(tlo[c]) - 1, 1'b0, 8'h00, "R3 R4 R6 just below");
      for (int d = 0; d < 4096; d += 61)
        step(1'b1, c, d, 1'b0, 8'h00, "R5 R6 sweep latched");
      step(1'b1, c, 2048, 1'b0, 8'h00, "R5 back in window");
    end

    // R7 R8: partial clear, then mixed clear and detect
    step(1'b0, 0, 0, 1'b1, 8'b1010_0000, "R7 R8 clear ch0 up ch1 up");
    step(1'b0, 0, 0, 1'b1, 8'b0000_0001, "R7 R8 clear ch3 low");
    step(1'b1, 1, 4000, 1'b1, 8'b0010_0000, "R7 clear loses to detect");
    step(1'b1, 2, 5, 1'b1, 8'b0000_0100, "R7 R6 recapture after clear");
    step(1'b1, 3, 10, 1'b1, 8'b0001_0000, "R7 other bit cleared");
    for (int m = 0; m < 256; m += 17) begin
      step(1'b1, m % NCH, (m * 23) % 4096, 1'b0, 8'h00, "R6 R7 mixed arm");
      step(1'b0, 0, 0, 1'b1, 8'(m), "R7 R8 mask sweep");
    end

    // R10: enable toggling with pending alarms and with none
    step(1'b1, 0, 4095, 1'b0, 8'h00, "R10 arm");
    irq_en = 1'b0; #1; check("R10 disabled");
    irq_en = 1'b1; #1; check("R10 enabled");
    step(1'b0, 0, 0, 1'b1, 8'hFF, "R7 R10 clear all");
    irq_en = 1'b0; #1; check("R10 disabled idle");

    // R1: reset mid-run
    step(1'b1, 2, 0, 1'b0, 8'h00, "R11 arm before reset");
    rst_n = 1'b0;
    exp_st = 8'h00;
    for (int c = 0; c < NCH; c++) exp_f[c] = '0;
    @(negedge clk);
    check("R1 reset mid-run");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 release");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule